// File: doc/BRIEF.md
# Memory Bank Address Decoder

This block sits between the bus masters and the memory control machines of a chip. It holds eight bank descriptors. Each descriptor gives an address window as a base and a mask, a valid bit, a write-protect bit, a set of permitted access types, and the control machine that serves the bank. Every request captured from the bus is matched against all eight windows. The block returns a one-hot bank select and the identifier of the machine that should run the cycle. When the request cannot be served, it raises a protection error, an access-type error or a no-hit flag instead.

Software programs the descriptors through a plain write port that carries two words per bank: an attribute word and a mask word. The request is registered on the clock edge. The decode that follows is combinational, so the result for a request appears during the cycle after the request is captured. Requests from external masters take the same address and protection path as requests from internal masters. The access-type filter applies only to internal masters.

Top module: `bank_decoder`

## Requirements
- R1: Eight descriptors are written through `cfg_we`, `cfg_bank` and `cfg_sel`. With `cfg_sel`=0 the attribute word is written, laid out as base address bits 31:15 in bits 31:15, allowed-type mask in bits 7:4, machine code in bits 3:2, write-protect in bit 1 and valid in bit 0. With `cfg_sel`=1 the mask word is written, with mask bits 31:15 in bits 31:15. Reset clears every descriptor, so every bank is invalid. A bank whose valid bit is 0 never matches.
- R2: A bank matches when address bits 31:15 equal its base bits in every position where its mask bit is 1. Address bits 14:0 never take part in the match. An all-ones mask gives a 32 KB window, and an all-zero mask matches the entire 4 GB space.
- R3: A request presented with `req_valid`=1 is captured on a rising edge. Its results are driven in the following cycle with `out_valid`=1. In a cycle with `out_valid`=0, `bank_sel`, `mach_id` and all three flags are 0.
- R4: When several valid banks match, only the lowest-numbered one is considered. `bank_sel` is never more than one-hot, and bit i of `bank_sel` stands for bank i.
- R5: When no valid bank matches, `miss`=1 and `bank_sel`=0.
- R6: A write (`req_write`=1) to a winning bank whose write-protect bit is set raises `wp_err` and leaves `bank_sel` at 0. A read of that bank selects it normally.
- R7: An internal access (`req_ext`=0) with type code t (2 bits, 0..3) to a winning bank whose allowed-type bit t is 0 raises `type_err` and leaves `bank_sel` at 0.
- R8: External accesses (`req_ext`=1) are decoded for address, priority and write protection exactly as internal ones, but they are not filtered by access type.
- R9: `mach_id` gives the winning bank's machine: 0 is the simple non-burst machine, 1 is pattern machine A and 2 is pattern machine B. A stored code of 3 is treated as 0. `mach_id` is 0 whenever `bank_sel` is 0.
- R10: Errors are judged on the winning bank alone. A rejected access to the lowest matching bank does not fall through to a higher matching bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_bank | input | 3 | Bank index for the write |
| cfg_sel | input | 1 | 0 = attribute word, 1 = mask word |
| cfg_wdata | input | 32 | Descriptor write data |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_type | input | 2 | Access-type code |
| req_ext | input | 1 | 1 = request from an external master |
| out_valid | output | 1 | Decode result valid |
| bank_sel | output | 8 | One-hot bank select |
| mach_id | output | 2 | Control machine for the selected bank |
| wp_err | output | 1 | Write-protect violation |
| type_err | output | 1 | Access-type violation |
| miss | output | 1 | No valid bank matched |

## Verification
The bench builds overlapping windows and checks that the lower bank wins. A design that scanned from the top, or one that let a rejected access fall through to the next bank, would select the wrong bit. It probes addresses one byte inside and one byte outside a 32 KB window, and it also programs a bank with an all-zero mask. A compare that used the low 15 bits, or that mishandled the mask, would miss or hit falsely. It sends writes and reads to protected banks, and sends disallowed types from both internal and external masters. A filter applied to external masters, or a protection check that ignored direction, would flag the wrong access. It also sets a machine code of 3 and clears a valid bit to confirm those banks behave as R9 and R1 state.

// File: rtl/bank_dec_pkg.sv
// Package: shared constants and types for the memory bank address decoder.
// Assumes a 32-bit byte address and a 32 KB minimum bank granule.
package bank_dec_pkg;
    localparam int ADDR_W    = 32;
    localparam int PAGE_LSB  = 15;
    localparam int TAG_W     = ADDR_W - PAGE_LSB;
    localparam int TYPE_W    = 2;
    localparam int NUM_TYPES = 1 << TYPE_W;
    localparam int MACH_W    = 2;

    // Attribute word field positions
    localparam int ATTR_VALID_BIT = 0;
    localparam int ATTR_WP_BIT    = 1;
    localparam int ATTR_MACH_LSB  = 2;
    localparam int ATTR_TYPES_LSB = 4;

    typedef enum logic [MACH_W-1:0] {
        MACH_SIMPLE = 2'd0,
        MACH_PAT_A  = 2'd1,
        MACH_PAT_B  = 2'd2
    } mach_e;

    typedef struct packed {
        logic [TAG_W-1:0]     base;
        logic [TAG_W-1:0]     mask;
        logic [NUM_TYPES-1:0] types;
        mach_e                mach;
        logic                 wp;
        logic                 valid;
    } bank_cfg_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [TYPE_W-1:0] atype;
        logic              ext;
    } req_t;
endpackage

// File: rtl/bank_regs.sv
// Module: descriptor storage. Holds NUM_BANKS bank descriptors written
// through a single write port. Assumes cfg_bank is below NUM_BANKS;
// other indices are ignored. A machine code of 3 is stored as the simple machine.
module bank_regs
    import bank_dec_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [BANK_W-1:0]               cfg_bank,
    input  logic                            cfg_sel,
    input  logic [ADDR_W-1:0]               cfg_wdata,
    output bank_cfg_t [NUM_BANKS-1:0]       cfg_o
);
    logic [MACH_W-1:0] mach_raw;
    mach_e             mach_norm;

    // Map the written machine code onto a legal machine
    always_comb begin
        mach_raw = cfg_wdata[ATTR_MACH_LSB +: MACH_W];
        case (mach_raw)
            2'd1:    mach_norm = MACH_PAT_A;
            2'd2:    mach_norm = MACH_PAT_B;
            default: mach_norm = MACH_SIMPLE;
        endcase
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Update one descriptor on a matching write; clear on reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_o[b] <= '0;
            end else if (cfg_we && (cfg_bank == BANK_W'(b))) begin
                if (cfg_sel) begin
                    cfg_o[b].mask <= cfg_wdata[ADDR_W-1:PAGE_LSB];
                end else begin
                    cfg_o[b].base  <= cfg_wdata[ADDR_W-1:PAGE_LSB];
                    cfg_o[b].types <= cfg_wdata[ATTR_TYPES_LSB +: NUM_TYPES];
                    cfg_o[b].mach  <= mach_norm;
                    cfg_o[b].wp    <= cfg_wdata[ATTR_WP_BIT];
                    cfg_o[b].valid <= cfg_wdata[ATTR_VALID_BIT];
                end
            end
        end
    end
endmodule

// File: rtl/bank_match.sv
// Module: per-bank window compare. Produces one hit bit per valid bank
// whose base equals the address tag under that bank's mask.
// Assumes address bits below PAGE_LSB never take part.
module bank_match
    import bank_dec_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input  logic [ADDR_W-1:0]          addr,
    input  bank_cfg_t [NUM_BANKS-1:0]  cfg,
    output logic [NUM_BANKS-1:0]       hit
);
    logic [TAG_W-1:0] tag;

    assign tag = addr[ADDR_W-1:PAGE_LSB];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cmp
        logic [TAG_W-1:0] diff;
        // Masked difference between address tag and bank base
        always_comb begin
            diff   = (tag ^ cfg[b].base) & cfg[b].mask;
            hit[b] = cfg[b].valid && (diff == '0);
        end
    end
endmodule

// File: rtl/bank_prio.sv
// Module: fixed-priority pick. Selects the lowest-numbered set bit of the
// hit vector and reports its index and whether any bit was set.
module bank_prio #(
    parameter int NUM_BANKS = 8,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic [NUM_BANKS-1:0] hit,
    output logic [NUM_BANKS-1:0] grant,
    output logic [BANK_W-1:0]    idx,
    output logic                 any
);
    // Scan from the top so the lowest index is written last and wins
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (hit[b]) begin
                grant = '0;
                grant[b] = 1'b1;
                idx   = BANK_W'(b);
                any   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bank_check.sv
// Module: access rules for the winning bank. Applies write protection
// and, for internal masters only, the access-type filter. Assumes the
// winner descriptor and grant come from the priority stage.
module bank_check
    import bank_dec_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input  logic                 active,
    input  logic                 any,
    input  logic [NUM_BANKS-1:0] grant,
    input  bank_cfg_t            win,
    input  logic                 write,
    input  logic [TYPE_W-1:0]    atype,
    input  logic                 ext,
    output logic [NUM_BANKS-1:0] sel,
    output logic [MACH_W-1:0]    mach,
    output logic                 wp_err,
    output logic                 type_err,
    output logic                 miss
);
    logic hit_ok;

    // Judge the winner and gate every result with the active request
    always_comb begin
        miss     = active && !any;
        wp_err   = active && any && win.wp && write;
        type_err = active && any && !ext && !win.types[atype];
        hit_ok   = active && any && !wp_err && !type_err;
        sel      = hit_ok ? grant : '0;
        mach     = hit_ok ? win.mach : MACH_SIMPLE;
    end
endmodule

// File: rtl/bank_decoder.sv
// Module: memory bank address decoder top. Registers each bus request,
// then decodes it combinationally against the bank descriptors, so results
// are valid in the cycle after capture. Assumes a synchronous active-low reset.
module bank_decoder
    import bank_dec_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [BANK_W-1:0]    cfg_bank,
    input  logic                 cfg_sel,
    input  logic [31:0]          cfg_wdata,
    input  logic                 req_valid,
    input  logic [31:0]          req_addr,
    input  logic                 req_write,
    input  logic [1:0]           req_type,
    input  logic                 req_ext,
    output logic                 out_valid,
    output logic [NUM_BANKS-1:0] bank_sel,
    output logic [1:0]           mach_id,
    output logic                 wp_err,
    output logic                 type_err,
    output logic                 miss
);
    bank_cfg_t [NUM_BANKS-1:0] cfg;
    req_t                      req_q;
    logic [NUM_BANKS-1:0]      hit;
    logic [NUM_BANKS-1:0]      grant;
    logic [BANK_W-1:0]         win_idx;
    logic                      any_hit;
    bank_cfg_t                 win_cfg;

    bank_regs #(.NUM_BANKS(NUM_BANKS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_bank  (cfg_bank),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_o     (cfg)
    );

    // Capture the incoming request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q.valid <= req_valid;
            req_q.addr  <= req_addr;
            req_q.write <= req_write;
            req_q.atype <= req_type;
            req_q.ext   <= req_ext;
        end
    end

    bank_match #(.NUM_BANKS(NUM_BANKS)) u_match (
        .addr (req_q.addr),
        .cfg  (cfg),
        .hit  (hit)
    );

    bank_prio #(.NUM_BANKS(NUM_BANKS)) u_prio (
        .hit   (hit),
        .grant (grant),
        .idx   (win_idx),
        .any   (any_hit)
    );

    // Fetch the winning descriptor
    always_comb win_cfg = cfg[win_idx];

    bank_check #(.NUM_BANKS(NUM_BANKS)) u_check (
        .active   (req_q.valid),
        .any      (any_hit),
        .grant    (grant),
        .win      (win_cfg),
        .write    (req_q.write),
        .atype    (req_q.atype),
        .ext      (req_q.ext),
        .sel      (bank_sel),
        .mach     (mach_id),
        .wp_err   (wp_err),
        .type_err (type_err),
        .miss     (miss)
    );

    // Result qualifier
    assign out_valid = req_q.valid;
endmodule

// File: rtl/bank_decoder_chk.sv
// Module: property checker for bank_decoder, attached by bind.
// Relates the request port to the decode outputs over time.
module bank_decoder_chk #(
    parameter int NUM_BANKS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 out_valid,
    input logic [NUM_BANKS-1:0] bank_sel,
    input logic [1:0]           mach_id,
    input logic                 wp_err,
    input logic                 type_err,
    input logic                 miss
);
    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (bank_sel == '0 && !wp_err && !type_err && !miss));

    // R4
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_sel));

    // R5
    miss_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (bank_sel == '0 && !wp_err && !type_err));

    // R6
    wp_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wp_err |-> bank_sel == '0);

    // R7
    type_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        type_err |-> bank_sel == '0);

    // R9
    mach_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mach_id != 2'd3) && (bank_sel == '0 -> mach_id == 2'd0));

    // R5
    outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones({|bank_sel, miss, (wp_err | type_err)}) == 1));
endmodule

bind bank_decoder bank_decoder_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .out_valid (out_valid),
    .bank_sel  (bank_sel),
    .mach_id   (mach_id),
    .wp_err    (wp_err),
    .type_err  (type_err),
    .miss      (miss)
);

// File: tb/bank_decoder_tb.sv
// Directed bench for bank_decoder: one task per scenario, each checking its own results.
module bank_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_bank = '0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_type = '0;
    logic        req_ext = 1'b0;
    logic        out_valid;
    logic [7:0]  bank_sel;
    logic [1:0]  mach_id;
    logic        wp_err, type_err, miss;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bank_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_write(req_write), .req_type(req_type),
        .req_ext(req_ext), .out_valid(out_valid), .bank_sel(bank_sel),
        .mach_id(mach_id), .wp_err(wp_err), .type_err(type_err), .miss(miss)
    );

    function automatic logic [31:0] attr(input logic [31:0] base, input logic [3:0] types,
                                         input logic [1:0] mach, input logic wp, input logic vld);
        return {base[31:15], 7'd0, types, mach, wp, vld};
    endfunction

    task automatic write_bank(input int b, input logic [31:0] a_word, input logic [31:0] m_word);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank = 3'(b); cfg_sel = 1'b0; cfg_wdata = a_word;
        @(negedge clk);
        cfg_sel = 1'b1; cfg_wdata = m_word;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Present one request, then sample in the following cycle
    task automatic send(input logic [31:0] a, input logic wr, input logic [1:0] t, input logic ext);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_type = t; req_ext = ext;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_out(input string tag, input logic [7:0] e_sel, input logic [1:0] e_mach,
                              input logic e_wp, input logic e_ty, input logic e_miss, input logic e_v);
        checks++;
        if (out_valid !== e_v || bank_sel !== e_sel || mach_id !== e_mach ||
            wp_err !== e_wp || type_err !== e_ty || miss !== e_miss) begin
            errors++;
            $display("FAIL %s: got v=%b sel=%h mach=%0d wp=%b ty=%b miss=%b, expected v=%b sel=%h mach=%0d wp=%b ty=%b miss=%b",
                     tag, out_valid, bank_sel, mach_id, wp_err, type_err, miss,
                     e_v, e_sel, e_mach, e_wp, e_ty, e_miss);
        end
    endtask

    task automatic t_reset();
        // R3: idle after reset
        expect_out("R3 reset idle", 8'h00, 2'd0, 0, 0, 0, 0);
        // R1: all banks invalid after reset
        send(32'h0000_0000, 0, 2'd0, 0);
        expect_out("R1 reset miss", 8'h00, 2'd0, 0, 0, 1, 1);
    endtask

    task automatic t_window();
        write_bank(3, attr(32'h1000_0000, 4'hF, 2'd1, 0, 1), 32'hFFFF_8000);
        send(32'h1000_7FFF, 0, 2'd0, 0);
        expect_out("R2 inside 32KB", 8'h08, 2'd1, 0, 0, 0, 1);
        send(32'h1000_8000, 0, 2'd0, 0);
        expect_out("R2 R5 outside 32KB", 8'h00, 2'd0, 0, 0, 1, 1);
    endtask

    task automatic t_priority();
        write_bank(1, attr(32'h1000_0000, 4'hF, 2'd2, 0, 1), 32'hF000_0000);
        send(32'h1000_0010, 0, 2'd0, 0);
        expect_out("R4 lowest wins", 8'h02, 2'd2, 0, 0, 0, 1);
        send(32'h1800_0000, 1, 2'd3, 0);
        expect_out("R4 single hit", 8'h02, 2'd2, 0, 0, 0, 1);
    endtask

    task automatic t_protect();
        write_bank(5, attr(32'h4000_0000, 4'hF, 2'd0, 1, 1), 32'hFFF0_0000);
        send(32'h4000_1000, 1, 2'd0, 0);
        expect_out("R6 write blocked", 8'h00, 2'd0, 1, 0, 0, 1);
        send(32'h4000_1000, 0, 2'd0, 0);
        expect_out("R6 read allowed", 8'h20, 2'd0, 0, 0, 0, 1);
    endtask

    task automatic t_types();
        write_bank(6, attr(32'h5000_0000, 4'b0010, 2'd3, 0, 1), 32'hFFFF_0000);
        send(32'h5000_0004, 0, 2'd1, 0);
        expect_out("R9 code3 as simple", 8'h40, 2'd0, 0, 0, 0, 1);
        send(32'h5000_0004, 0, 2'd2, 0);
        expect_out("R7 type rejected", 8'h00, 2'd0, 0, 1, 0, 1);
        send(32'h5000_0004, 1, 2'd2, 1);
        expect_out("R8 external bypasses type", 8'h40, 2'd0, 0, 0, 0, 1);
        send(32'h4000_0000, 1, 2'd0, 1);
        expect_out("R8 external write protected", 8'h00, 2'd0, 1, 0, 0, 1);
    endtask

    task automatic t_nofall();
        write_bank(2, attr(32'h6000_0000, 4'hF, 2'd2, 0, 1), 32'hFF00_0000);
        write_bank(0, attr(32'h6000_0000, 4'hF, 2'd1, 1, 1), 32'hFFFF_0000);
        send(32'h6000_0040, 1, 2'd0, 0);
        expect_out("R10 no fall-through", 8'h00, 2'd0, 1, 0, 0, 1);
        send(32'h6001_0000, 1, 2'd0, 0);
        expect_out("R10 higher bank alone", 8'h04, 2'd2, 0, 0, 0, 1);
        write_bank(0, attr(32'h6000_0000, 4'hF, 2'd1, 1, 0), 32'hFFFF_0000);
        send(32'h6000_0040, 1, 2'd0, 0);
        expect_out("R1 invalid bank ignored", 8'h04, 2'd2, 0, 0, 0, 1);
    endtask

    task automatic t_full_space();
        send(32'hFFFF_FFFF, 0, 2'd0, 0);
        expect_out("R5 top address miss", 8'h00, 2'd0, 0, 0, 1, 1);
        write_bank(7, attr(32'hABCD_0000, 4'hF, 2'd1, 0, 1), 32'h0000_0000);
        send(32'hFFFF_FFFF, 0, 2'd0, 0);
        expect_out("R2 zero mask 4GB", 8'h80, 2'd1, 0, 0, 0, 1);
        @(negedge clk);
        expect_out("R3 idle after request", 8'h00, 2'd0, 0, 0, 0, 0);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h1000_0000; req_write = 0; req_type = 0; req_ext = 0;
        @(negedge clk);
        expect_out("R3 first of pair", 8'h02, 2'd2, 0, 0, 0, 1);
        req_addr = 32'h4000_0000; req_write = 1;
        @(negedge clk);
        req_valid = 1'b0;
        expect_out("R3 second of pair", 8'h00, 2'd0, 1, 0, 0, 1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_window();
        t_priority();
        t_protect();
        t_types();
        t_nofall();
        t_full_space();
        t_back_to_back();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule